// File: doc/BRIEF.md
# Per-Row Activation Throttle

This block sits between the request side of a DRAM controller and its command scheduler and limits how often any one row may be opened. Repeatedly opening the same row disturbs the charge in neighbouring rows, so the throttle enforces two limits on each row. The first is a minimum spacing, in clock cycles, between two activations of that row. The second is a maximum number of activations of that row within one refresh window. Requests to rows that are within both limits pass straight through in the same cycle.

Per-row history lives in a small fully associative table. Each slot holds a row address, a saturating gap counter and a window activation count, and the slots are ordered by recency. A requested row that misses the table is always legal. When it is granted it takes the least recently granted slot, starting with a count of 1 and a fresh gap. A row that hits the table is granted only when its gap has elapsed and its count is below the cap. Otherwise it is stalled, and the requester keeps the same row on the port until the grant comes. A refresh-window tick from outside clears every count.

Every cycle the decision logic makes one of five named decisions. IDLE means no request. GRANT_HIT means a tracked row is within both limits. GRANT_NEW means an untracked row, which is granted and allocated. STALL_GAP means a tracked row whose spacing has not elapsed. STALL_CAP means a tracked row that has reached the cap. Only the GRANT decisions change the table, through a slot refresh or a slot allocation and a recency update. STALL decisions and IDLE leave it unchanged apart from the free-running gap counters.

Top module: `act_throttle`

## Requirements
- R1: While no row is tracked (after reset), any request is granted in the same cycle it is presented.
- R2: A row granted in cycle t is stalled (stall=1, grant=0) if requested in any cycle t+1 to t+MIN_GAP-1 while it is still tracked.
- R3: A tracked row held on the port is granted in cycle t+MIN_GAP, exactly MIN_GAP cycles after its previous grant, provided its count is below CAP.
- R4: Once a tracked row has been granted CAP times since the last refresh-window tick, further requests for it stall even after the gap has elapsed.
- R5: A tick clears all counts from the next cycle on. A request in the tick cycle itself is judged on the old count. A grant in the tick cycle counts as the first activation of the new window.
- R6: A request for a row other than one being held back is decided on its own history and is not blocked.
- R7: On a miss with the table full, the slot of the least recently granted row is reused. That row's history is lost, and a grant refreshes a row's recency.
- R8: With req_valid=1 exactly one of grant and stall is 1. With req_valid=0 both are 0.
- R9: The refresh-window tick does not shorten the minimum gap of a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties the table |
| req_valid | input | 1 | An activation request is presented |
| req_row | input | ROW_W | Row address of the request; held while stalled |
| win_tick | input | 1 | One-cycle pulse marking the start of a new refresh window |
| grant | output | 1 | Request may be issued this cycle |
| stall | output | 1 | Request must wait and be presented again |

## Verification
The hardest situation to reach from the ports is eviction of a row whose spacing has not yet elapsed. Only that case shows whether replacement follows recency order rather than fill order. The bench uses a two-slot table with a four-cycle gap and refreshes one row with a hit before a third row arrives. It then checks in the next cycles that the refreshed row is still held back and that the evicted row is granted early. Cap behaviour at a window boundary is reached by spacing grants exactly one gap apart and placing the tick on a grant cycle and on a stall cycle.

// File: rtl/thr_pkg.sv
package thr_pkg;

    // Per-cycle decision of the throttle
    typedef enum logic [2:0] {
        DEC_IDLE,
        DEC_GRANT_HIT,
        DEC_GRANT_NEW,
        DEC_STALL_GAP,
        DEC_STALL_CAP
    } dec_e;

endpackage

// File: rtl/thr_match.sv
// Fully associative lookup of the requested row among the valid slots.
module thr_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ROW_W   = 16,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [ENTRIES-1:0]            slot_vld,
    input  logic [ENTRIES-1:0][ROW_W-1:0] slot_row,
    input  logic [ROW_W-1:0]              key_row,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!hit && slot_vld[i] && (slot_row[i] == key_row)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/thr_lru.sv
// Recency ranks: 0 is most recently granted, ENTRIES-1 is the next victim.
module thr_lru #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][IDX_W-1:0] rank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                rank_q[i] <= IDX_W'(i);
            end
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    rank_q[i] <= '0;
                end else if (rank_q[i] < rank_q[touch_idx]) begin
                    rank_q[i] <= rank_q[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rank_q[i] == OLDEST) begin
                victim_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/thr_slot.sv
// One table slot: row tag, saturating gap counter, window activation count.
module thr_slot #(
    parameter int unsigned ROW_W   = 16,
    parameter int unsigned GAP_W   = 7,
    parameter int unsigned CNT_W   = 18,
    parameter int unsigned GAP_M1  = 124,
    parameter int unsigned CAP     = 131072
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_tick,
    input  logic             load,
    input  logic             bump,
    input  logic [ROW_W-1:0] new_row,
    output logic             vld,
    output logic [ROW_W-1:0] row,
    output logic             gap_ok,
    output logic             cap_ok
);

    localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(GAP_M1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CAP);

    logic [GAP_W-1:0] age_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= 1'b0;
            row   <= '0;
            age_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            vld   <= 1'b1;
            row   <= new_row;
            age_q <= '0;
            cnt_q <= CNT_W'(1);
        end else if (bump) begin
            age_q <= '0;
            cnt_q <= win_tick ? CNT_W'(1) : cnt_q + 1'b1;
        end else begin
            if (age_q != GAP_SAT) begin
                age_q <= age_q + 1'b1;
            end
            if (win_tick) begin
                cnt_q <= '0;
            end
        end
    end

    assign gap_ok = (age_q == GAP_SAT);
    assign cap_ok = (cnt_q < CNT_MAX);

endmodule

// File: rtl/act_throttle.sv
module act_throttle #(
    parameter int unsigned ROW_W   = 16,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned MIN_GAP = 125,
    parameter int unsigned CAP     = 131072
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic             win_tick,
    output logic             grant,
    output logic             stall
);
    import thr_pkg::*;

    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned GAP_M1 = MIN_GAP - 1;
    localparam int unsigned GAP_W  = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
    localparam int unsigned CNT_W  = $clog2(CAP + 1);

    logic [ENTRIES-1:0]            slot_vld;
    logic [ENTRIES-1:0][ROW_W-1:0] slot_row;
    logic [ENTRIES-1:0]            slot_gap_ok;
    logic [ENTRIES-1:0]            slot_cap_ok;
    logic [ENTRIES-1:0]            slot_load;
    logic [ENTRIES-1:0]            slot_bump;

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim_idx;
    logic             touch;
    logic [IDX_W-1:0] touch_idx;
    dec_e             dec;

    thr_match #(.ENTRIES(ENTRIES), .ROW_W(ROW_W), .IDX_W(IDX_W)) match_i (
        .slot_vld (slot_vld),
        .slot_row (slot_row),
        .key_row  (req_row),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    thr_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) lru_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        thr_slot #(
            .ROW_W (ROW_W), .GAP_W (GAP_W), .CNT_W (CNT_W),
            .GAP_M1(GAP_M1), .CAP  (CAP)
        ) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .win_tick (win_tick),
            .load     (slot_load[g]),
            .bump     (slot_bump[g]),
            .new_row  (req_row),
            .vld      (slot_vld[g]),
            .row      (slot_row[g]),
            .gap_ok   (slot_gap_ok[g]),
            .cap_ok   (slot_cap_ok[g])
        );
    end

    // Decision for the presented request
    always_comb begin
        if (!req_valid) begin
            dec = DEC_IDLE;
        end else if (!hit) begin
            dec = DEC_GRANT_NEW;
        end else if (!slot_cap_ok[hit_idx]) begin
            dec = DEC_STALL_CAP;
        end else if (!slot_gap_ok[hit_idx]) begin
            dec = DEC_STALL_GAP;
        end else begin
            dec = DEC_GRANT_HIT;
        end
    end

    // Outputs and table controls per decision
    always_comb begin
        grant     = 1'b0;
        stall     = 1'b0;
        touch     = 1'b0;
        touch_idx = hit_idx;
        slot_load = '0;
        slot_bump = '0;
        unique case (dec)
            DEC_IDLE: begin
            end
            DEC_GRANT_HIT: begin
                grant              = 1'b1;
                touch              = 1'b1;
                slot_bump[hit_idx] = 1'b1;
            end
            DEC_GRANT_NEW: begin
                grant                 = 1'b1;
                touch                 = 1'b1;
                touch_idx             = victim_idx;
                slot_load[victim_idx] = 1'b1;
            end
            DEC_STALL_GAP, DEC_STALL_CAP: begin
                stall = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/act_throttle_chk.sv
module act_throttle_chk #(
    parameter int unsigned ROW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [ROW_W-1:0] req_row,
    input logic             grant,
    input logic             stall
);

    logic seen_grant_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_grant_q <= 1'b0;
        end else if (grant) begin
            seen_grant_q <= 1'b1;
        end
    end

    // R8
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones({grant, stall}) == 1));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !stall));

    // R1
    empty_table_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seen_grant_q) |-> grant);

    // R2
    back_to_back_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grant) && req_valid && (req_row == $past(req_row))) |-> stall);

endmodule

bind act_throttle act_throttle_chk #(.ROW_W(ROW_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_row   (req_row),
    .grant     (grant),
    .stall     (stall)
);

// File: tb/act_throttle_tb_top.sv
module act_throttle_tb_top;

    localparam int unsigned ROW_W   = 8;
    localparam int unsigned ENTRIES = 2;
    localparam int unsigned MIN_GAP = 4;
    localparam int unsigned CAP     = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic             win_tick = 1'b0;
    logic             grant;
    logic             stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    act_throttle #(
        .ROW_W(ROW_W), .ENTRIES(ENTRIES), .MIN_GAP(MIN_GAP), .CAP(CAP)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_row   (req_row),
        .win_tick  (win_tick),
        .grant     (grant),
        .stall     (stall)
    );

    // One cycle: drive after the falling edge, sample before the rising edge
    task automatic cyc(input bit v, input logic [ROW_W-1:0] row, input bit tick,
                       input bit exp_g, input bit exp_s, input string req);
        @(negedge clk);
        req_valid = v;
        req_row   = row;
        win_tick  = tick;
        #1;
        checks++;
        if (grant !== exp_g || stall !== exp_s) begin
            fails++;
            $display("FAIL %s row=%0d: grant/stall=%b%b expected %b%b",
                     req, row, grant, stall, exp_g, exp_s);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, "R8 idle");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        win_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1, R8: reset state and first grant
    task automatic t_reset();
        do_reset();
        idle(2);
        cyc(1'b1, 8'd10, 1'b0, 1'b1, 1'b0, "R1 first request");
        cyc(1'b1, 8'd11, 1'b0, 1'b1, 1'b0, "R1 second new row");
    endtask

    // R2, R3: held request released exactly MIN_GAP after its grant
    task automatic t_gap();
        do_reset();
        cyc(1'b1, 8'd20, 1'b0, 1'b1, 1'b0, "R3 initial grant");
        for (int k = 1; k < MIN_GAP; k++)
            cyc(1'b1, 8'd20, 1'b0, 1'b0, 1'b1, "R2 inside gap");
        cyc(1'b1, 8'd20, 1'b0, 1'b1, 1'b0, "R3 gap elapsed");
        cyc(1'b1, 8'd20, 1'b0, 1'b0, 1'b1, "R2 again after re-grant");
    endtask

    // R6: another row passes while one is held back
    task automatic t_other();
        do_reset();
        cyc(1'b1, 8'd30, 1'b0, 1'b1, 1'b0, "R6 first row");
        cyc(1'b1, 8'd30, 1'b0, 1'b0, 1'b1, "R2 first row held");
        cyc(1'b1, 8'd31, 1'b0, 1'b1, 1'b0, "R6 other row granted");
        cyc(1'b1, 8'd30, 1'b0, 1'b0, 1'b1, "R6 first row still held");
        cyc(1'b1, 8'd30, 1'b0, 1'b1, 1'b0, "R3 first row released");
    endtask

    // R4, R5: cap reached, tick in a stall cycle, release after tick
    task automatic t_cap();
        do_reset();
        for (int n = 0; n < CAP; n++) begin
            cyc(1'b1, 8'd40, 1'b0, 1'b1, 1'b0, "R4 grant below cap");
            idle(MIN_GAP - 1);
        end
        cyc(1'b1, 8'd40, 1'b0, 1'b0, 1'b1, "R4 cap reached");
        cyc(1'b1, 8'd40, 1'b0, 1'b0, 1'b1, "R4 cap still held");
        cyc(1'b1, 8'd41, 1'b0, 1'b1, 1'b0, "R6 other row during cap");
        cyc(1'b1, 8'd40, 1'b1, 1'b0, 1'b1, "R5 tick cycle uses old count");
        cyc(1'b1, 8'd40, 1'b0, 1'b1, 1'b0, "R5 released after tick");
    endtask

    // R5: a grant in the tick cycle is the first of the new window
    task automatic t_tick_grant();
        do_reset();
        for (int n = 0; n < CAP - 1; n++) begin
            cyc(1'b1, 8'd70, 1'b0, 1'b1, 1'b0, "R4 fill window");
            idle(MIN_GAP - 1);
        end
        cyc(1'b1, 8'd70, 1'b1, 1'b1, 1'b0, "R5 grant in tick cycle");
        idle(MIN_GAP - 1);
        for (int n = 1; n < CAP; n++) begin
            cyc(1'b1, 8'd70, 1'b0, 1'b1, 1'b0, "R5 new window grants");
            idle(MIN_GAP - 1);
        end
        cyc(1'b1, 8'd70, 1'b0, 1'b0, 1'b1, "R5 tick grant counted once");
    endtask

    // R9: tick does not release a gap stall
    task automatic t_tick_gap();
        do_reset();
        cyc(1'b1, 8'd50, 1'b0, 1'b1, 1'b0, "R9 grant");
        cyc(1'b1, 8'd50, 1'b1, 1'b0, 1'b1, "R9 tick cycle in gap");
        cyc(1'b1, 8'd50, 1'b0, 1'b0, 1'b1, "R9 after tick still in gap");
    endtask

    // R7: LRU replacement with a two-slot table
    task automatic t_lru();
        do_reset();
        cyc(1'b1, 8'd1, 1'b0, 1'b1, 1'b0, "R7 fill a");
        cyc(1'b1, 8'd2, 1'b0, 1'b1, 1'b0, "R7 fill b");
        cyc(1'b1, 8'd3, 1'b0, 1'b1, 1'b0, "R7 miss evicts a");
        cyc(1'b1, 8'd1, 1'b0, 1'b1, 1'b0, "R7 evicted row has no history");
        cyc(1'b1, 8'd3, 1'b0, 1'b0, 1'b1, "R7 recent row still tracked");
        do_reset();
        cyc(1'b1, 8'd1, 1'b0, 1'b1, 1'b0, "R7 fill a");
        cyc(1'b1, 8'd2, 1'b0, 1'b1, 1'b0, "R7 fill b");
        idle(MIN_GAP - 2);
        cyc(1'b1, 8'd1, 1'b0, 1'b1, 1'b0, "R7 hit refreshes a");
        cyc(1'b1, 8'd3, 1'b0, 1'b1, 1'b0, "R7 miss evicts b");
        cyc(1'b1, 8'd1, 1'b0, 1'b0, 1'b1, "R7 refreshed row kept");
    endtask

    initial begin
        t_reset();
        t_gap();
        t_other();
        t_cap();
        t_tick_grant();
        t_tick_gap();
        t_lru();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule